// File: doc/BRIEF.md
# Per-Hart Machine Timer Comparator

This block keeps one 64-bit time base shared by every hart of a multi-hart cluster, together with one 64-bit compare value per hart, and drives a level timer interrupt to each hart. The time base counts up by one on every clock cycle in which a tick-enable input is high. A hart's interrupt is held high for as long as its compare value is at or below the current time.

Software reaches the block through a plain 32-bit register bus that carries an address, a read strobe, a write strobe, write data and registered read data. Each 64-bit quantity appears as two 32-bit words in little-endian order. Writing a compare word changes only that word, and the interrupt is re-evaluated from the new value on the next cycle. The time base cannot be written from the bus. The compare slots sit at an 8-byte stride starting at a compare base, and the two time words sit at a separate time base. Both base offsets must be multiples of 8, and the hart count may not exceed the maximum parameter.

Top module: `hart_timer_unit`

## Requirements
- R1: After reset the time base is 0, every compare register holds all ones, every interrupt output is low, and the read data is 0.
- R2: The time base increases by exactly one at each clock edge where `tick_en` is high, and holds its value at every other edge.
- R3: A read at `TIME_BASE` returns time bits 31:0, and a read at `TIME_BASE`+4 returns bits 63:32. Writes to either address leave the time base unchanged.
- R4: Hart h's compare register sits at `CMP_BASE` + 8*h. Byte offset 0 of the slot holds bits 31:0 and offset 4 holds bits 63:32. Both words read back what was last written to them.
- R5: A write to one word of a compare register leaves the other word unchanged.
- R6: Each interrupt output is registered. One cycle after any change, it shows whether that hart's compare value is less than or equal to the time base, and equality counts as pending.
- R7: Writing a compare value at or below the current time raises that hart's interrupt on the next cycle. Writing a value above the current time lowers it on the next cycle, and it rises again once the time base reaches the value.
- R8: A read from an address outside both register windows, or at an offset inside a window other than 0 or 4, returns 0. A write to such an address changes no state.
- R9: A compare write affects only the addressed hart's register and interrupt.
- R10: `bus_rdata` takes the selected word at the clock edge where `bus_rd` is high, and keeps its value through cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| tick_en | input | 1 | Advance the time base by one this cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| timer_irq | output | NUM_HARTS | Level timer interrupt, one per hart |

## Verification
The bench builds the block with three harts, a maximum of four, the compare window at 0x40 and the time words at 0x10. With three harts the bench can write one hart while checking that the other two are unaffected. The slot just past the third hart (0x58) is a mapped-looking address that lies outside the window, so it tests the end of the compare range. The time window ends just below 0x18, which lets the bench probe the address right after it. Small tick counts are enough to land the time base exactly on a programmed compare value, which covers the equality case and the one-cycle interrupt latency.

// File: rtl/htu_pkg.sv
package htu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TIME_W = 64;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [TIME_W-1:0] tval_t;

  // Result of decoding one bus address.
  typedef struct packed {
    logic hit;      // address maps to a register word
    logic is_time;  // time-base window rather than compare window
    logic upper;    // upper 32-bit word of the 64-bit register
  } dec_t;

  function automatic word_t pick_word(tval_t v, logic upper);
    return upper ? v[TIME_W-1:WORD_W] : v[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/htu_time_counter.sv
module htu_time_counter
  import htu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_en,
  output tval_t time_o
);
  tval_t time_q, time_d;

  always_comb begin
    time_d = time_q;
    if (tick_en) time_d = time_q + tval_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= '0;
    else if (tick_en) time_q <= time_d;
  end

  assign time_o = time_q;

  p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> time_q == $past(time_q) + tval_t'(1));

  p_time_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(time_q));
endmodule

// File: rtl/htu_cmp_slot.sv
module htu_cmp_slot
  import htu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_lo,
  input  logic  wr_hi,
  input  word_t wdata,
  input  tval_t time_i,
  output tval_t cmp_o,
  output logic  irq_o
);
  tval_t cmp_q, cmp_d;
  logic  irq_q, irq_d;
  logic  cmp_en;

  assign cmp_en = wr_lo | wr_hi;

  always_comb begin
    cmp_d = cmp_q;
    if (wr_lo) cmp_d[WORD_W-1:0]      = wdata;
    if (wr_hi) cmp_d[TIME_W-1:WORD_W] = wdata;
  end

  assign irq_d = (cmp_q <= time_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (cmp_en) cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign cmp_o = cmp_q;
  assign irq_o = irq_q;

  p_lo_keeps_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> cmp_q[TIME_W-1:WORD_W] == $past(cmp_q[TIME_W-1:WORD_W]));

  p_hi_keeps_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> cmp_q[WORD_W-1:0] == $past(cmp_q[WORD_W-1:0]));

  p_irq_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q <= time_i) |=> irq_o);

  p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q > time_i) |=> !irq_o);
endmodule

// File: rtl/htu_bus_decode.sv
module htu_bus_decode
  import htu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_HARTS = 1,
  parameter int unsigned IDX_W     = 1,
  parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
  parameter logic [ADDR_W-1:0] TIME_BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W:0] CMP_SPAN = (ADDR_W+1)'(NUM_HARTS * 8);

  logic [ADDR_W:0] cmp_off;
  logic            in_cmp;
  logic            in_time;

  always_comb begin
    cmp_off = {1'b0, addr} - {1'b0, CMP_BASE};
    in_cmp  = (addr >= CMP_BASE) && (cmp_off < CMP_SPAN) && (cmp_off[1:0] == 2'b00);
    in_time = (addr[ADDR_W-1:3] == TIME_BASE[ADDR_W-1:3]) && (addr[1:0] == 2'b00);
    idx     = cmp_off[IDX_W+2:3];
    dec.hit     = in_cmp | in_time;
    dec.is_time = in_time;
    dec.upper   = in_time ? addr[2] : cmp_off[2];
  end
endmodule

// File: rtl/hart_timer_unit.sv
module hart_timer_unit
  import htu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_HARTS = 1,
  parameter int unsigned MAX_HARTS = 8,
  parameter logic [ADDR_W-1:0] CMP_BASE  = 16'h4000,
  parameter logic [ADDR_W-1:0] TIME_BASE = 16'hBFF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NUM_HARTS-1:0] timer_irq
);
  localparam int unsigned IDX_W = (MAX_HARTS > 1) ? $clog2(MAX_HARTS) : 1;

  tval_t              time_now;
  tval_t              cmp_val [NUM_HARTS];
  dec_t               dec;
  logic [IDX_W-1:0]   hidx;
  logic [NUM_HARTS-1:0] wr_lo, wr_hi;
  word_t              rd_word;
  word_t              rdata_q, rdata_d;

  htu_time_counter u_time (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .time_o  (time_now)
  );

  htu_bus_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_HARTS (NUM_HARTS),
    .IDX_W     (IDX_W),
    .CMP_BASE  (CMP_BASE),
    .TIME_BASE (TIME_BASE)
  ) u_dec (
    .addr (bus_addr),
    .dec  (dec),
    .idx  (hidx)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic sel;
    assign sel      = bus_wr && dec.hit && !dec.is_time && (hidx == IDX_W'(h));
    assign wr_lo[h] = sel && !dec.upper;
    assign wr_hi[h] = sel &&  dec.upper;

    htu_cmp_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (wr_lo[h]),
      .wr_hi  (wr_hi[h]),
      .wdata  (bus_wdata),
      .time_i (time_now),
      .cmp_o  (cmp_val[h]),
      .irq_o  (timer_irq[h])
    );
  end

  always_comb begin
    rd_word = '0;
    if (dec.hit) begin
      if (dec.is_time) begin
        rd_word = pick_word(time_now, dec.upper);
      end else begin
        for (int h = 0; h < NUM_HARTS; h++) begin
          if (hidx == IDX_W'(h)) rd_word = pick_word(cmp_val[h], dec.upper);
        end
      end
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) rdata_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  p_one_word_written_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_lo, wr_hi}));

  p_miss_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !dec.hit) |=> bus_rdata == '0);

  p_rdata_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  p_time_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && dec.is_time && !tick_en) |=> $stable(time_now));
endmodule

// File: tb/hart_timer_unit_bench.sv
`timescale 1ns/1ps
module hart_timer_unit_bench;
  localparam int unsigned AW = 16;
  localparam int unsigned NH = 3;
  localparam logic [AW-1:0] CB = 16'h0040;
  localparam logic [AW-1:0] TB = 16'h0010;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NH-1:0] timer_irq;

  int errors = 0;
  int checks = 0;
  longint unsigned exp_time = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hart_timer_unit #(
    .ADDR_W(AW), .NUM_HARTS(NH), .MAX_HARTS(4), .CMP_BASE(CB), .TIME_BASE(TB)
  ) u_hart_timer_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .timer_irq(timer_irq)
  );

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    exp_time += longint'(n);
  endtask

  function automatic logic [AW-1:0] slot(int h, int off);
    return CB + AW'(8 * h + off);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq after reset", timer_irq, 0);
    chk("R1 rdata after reset", bus_rdata, 0);
    bus_read(TB, d);     chk("R1 time lo", d, 0);
    bus_read(TB + 4, d); chk("R1 time hi", d, 0);
    for (int h = 0; h < NH; h++) begin
      bus_read(slot(h, 0), d); chk("R1 cmp lo all ones", d, 32'hFFFF_FFFF);
      bus_read(slot(h, 4), d); chk("R1 cmp hi all ones", d, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_time();
    logic [31:0] d;
    ticks(10);
    bus_read(TB, d);     chk("R2 time after 10 ticks", d, exp_time);
    bus_read(TB + 4, d); chk("R3 time hi word", d, 0);
    repeat (5) @(negedge clk);
    bus_read(TB, d);     chk("R2 time holds without tick", d, exp_time);
    @(negedge clk);
    chk("R10 rdata held between reads", bus_rdata, exp_time);
    bus_write(TB, 32'h1234_5678);
    bus_write(TB + 4, 32'h0000_0099);
    bus_read(TB, d);     chk("R3 time lo write ignored", d, exp_time);
    bus_read(TB + 4, d); chk("R3 time hi write ignored", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    bus_write(slot(1, 0), 32'hAAAA_5555);
    bus_write(slot(1, 4), 32'h0000_0001);
    bus_read(slot(1, 0), d); chk("R4 hart1 lo readback", d, 32'hAAAA_5555);
    bus_read(slot(1, 4), d); chk("R4 hart1 hi readback", d, 32'h0000_0001);
    bus_write(slot(2, 0), 32'h0000_CAFE);
    bus_read(slot(2, 4), d); chk("R5 hi kept after lo write", d, 32'hFFFF_FFFF);
    bus_write(slot(2, 4), 32'h0);
    bus_read(slot(2, 0), d); chk("R5 lo kept after hi write", d, 32'h0000_CAFE);
    bus_read(slot(0, 0), d); chk("R9 hart0 untouched", d, 32'hFFFF_FFFF);
    chk("R7 future compare keeps irqs low", timer_irq, 0);
  endtask

  task automatic t_irq();
    bus_write(slot(0, 4), 32'h0);
    bus_write(slot(0, 0), 32'd5);
    @(negedge clk);
    chk("R7 past compare raises irq0", timer_irq, 3'b001);
    bus_write(slot(0, 0), 32'(exp_time + 20));
    @(negedge clk);
    chk("R7 future compare lowers irq0", timer_irq, 3'b000);
    ticks(19);
    chk("R6 one below compare stays low", timer_irq, 3'b000);
    ticks(1);
    chk("R6 irq registered one cycle late", timer_irq, 3'b000);
    @(negedge clk);
    chk("R6 irq at time equal compare", timer_irq, 3'b001);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_read(slot(3, 0), d); chk("R8 read past last hart", d, 0);
    bus_read(slot(0, 1), d); chk("R8 read bad offset", d, 0);
    bus_read(TB + 8, d);     chk("R8 read after time window", d, 0);
    bus_read(TB + 2, d);     chk("R8 read misaligned time", d, 0);
    bus_write(slot(3, 0), 32'h0);
    bus_write(slot(0, 2), 32'h0);
    bus_write(slot(0, 6), 32'h7777_7777);
    bus_read(slot(0, 0), d); chk("R8 hart0 lo unchanged", d, 30);
    bus_read(slot(0, 4), d); chk("R8 hart0 hi unchanged", d, 0);
    bus_read(slot(2, 0), d); chk("R8 hart2 lo unchanged", d, 32'h0000_CAFE);
    chk("R8 irqs unchanged", timer_irq, 3'b001);
  endtask

  task automatic t_indep();
    bus_write(slot(2, 0), 32'h0);
    @(negedge clk);
    chk("R9 irq2 raised alone", timer_irq, 3'b101);
    bus_write(slot(0, 4), 32'h1);
    @(negedge clk);
    chk("R9 irq0 lowered, irq2 kept", timer_irq, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_time();
    t_map();
    t_irq();
    t_unmapped();
    t_indep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule